// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a small square cursor over a video pixel stream. Software loads the cursor's shape into two bit planes, one row word per plane per line. The mask plane says which cursor pixels are drawn. The image plane picks one of two cursor colours for each drawn pixel. Software also writes one packed word that holds the cursor's position as signed X and Y. For every raster pixel, the block reports whether the cursor covers it and which cursor colour applies. It also passes the underlying pixel through with the same delay, so a later colour stage can do the mixing.

The cursor has no enable bit. To hide it, software moves it to minus 32 in both axes, which puts the whole shape off screen; reset does the same. A position write is held in a pending register and reaches the pixel logic only at the next frame-start pulse, so the cursor never tears within a frame. Hotspot arithmetic, trimming of the shape width, video timing and colour lookup all belong to other blocks.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, out_valid, out_hit and out_color_sel are 0, and the active and pending positions are both X = -32, Y = -32, so no raster pixel with non-negative coordinates is covered.
- R2: A write with wr_sel = 0 loads the pending position: X as a two's-complement value from wr_data[31:16] and Y from wr_data[15:0].
- R3: The active position changes only on a cycle with frame_start = 1, and then takes the pending value held before that edge. A position write in the same cycle waits for the next frame_start.
- R4: A write with wr_sel = 1 stores wr_data into mask row wr_idx, and a write with wr_sel = 2 stores it into image row wr_idx. A read of a row in the cycle it is written returns the old contents.
- R5: out_hit is 1 only when the pixel was valid, dx = pix_x - X and dy = pix_y - Y both lie in 0..31, and mask row dy has its column-dx bit set.
- R6: Column 0 (the leftmost cursor pixel) is bit 31 of a row word, and column 31 is bit 0.
- R7: out_color_sel equals bit dx of image row dy when out_hit is 1, and is 0 otherwise.
- R8: Results appear two clock edges after the pixel is presented. out_valid repeats pix_valid, and out_pix repeats pix_in, with that delay.
- R9: A cursor whose position is partly negative is drawn clipped: its on-screen part still follows R5 and R6.
- R10: A write with wr_sel = 3 changes neither the position nor either plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 position, 1 mask, 2 image, 3 none |
| wr_idx | input | 5 | Row index for plane writes |
| wr_data | input | 32 | Write data |
| frame_start | input | 1 | Start-of-frame pulse; commits the pending position |
| pix_valid | input | 1 | Raster pixel present |
| pix_x | input | 16 | Raster X, signed |
| pix_y | input | 16 | Raster Y, signed |
| pix_in | input | 24 | Underlying pixel |
| out_valid | output | 1 | Delayed pix_valid |
| out_hit | output | 1 | Cursor covers this pixel |
| out_color_sel | output | 1 | Cursor colour select (image bit) |
| out_pix | output | 24 | Delayed underlying pixel |

## Verification
The hardest cases to reach are the edges of the window, where dx or dy is exactly -1, 0, 31 or 32, and the clipped cursor at a negative position, where the subtraction has to carry through the sign. The bench sweeps full rectangles of raster coordinates that extend past every edge, once for a cursor fully on screen and once for a cursor at (-5, -7). It also places a position write in the same cycle as a frame_start pulse, and adds a write that targets nothing. A behavioural model with read-before-write row arrays checks every output on every cycle.

// File: rtl/curs_pkg.sv
package curs_pkg;
   typedef enum logic [1:0] {
      TGT_POS  = 2'd0,
      TGT_MASK = 2'd1,
      TGT_IMG  = 2'd2,
      TGT_NONE = 2'd3
   } wr_tgt_e;

   localparam int unsigned NUM_PLANES = 2;
   localparam int unsigned PLANE_MASK = 0;
   localparam int unsigned PLANE_IMG  = 1;
endpackage

// File: rtl/curs_pos_reg.sv
module curs_pos_reg #(
   parameter int unsigned COORD_W = 16,
   parameter int signed   HIDE_AT = -32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [2*COORD_W-1:0]     load_word,
   input  logic                     commit,
   output logic [2*COORD_W-1:0]     pend_word,
   output logic signed [COORD_W-1:0] act_x,
   output logic signed [COORD_W-1:0] act_y
);
   localparam logic [COORD_W-1:0] HIDE_C = COORD_W'(HIDE_AT);

   logic [2*COORD_W-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= {HIDE_C, HIDE_C};
         act_x  <= HIDE_C;
         act_y  <= HIDE_C;
      end else begin
         if (commit) begin
            act_x <= pend_q[2*COORD_W-1:COORD_W];
            act_y <= pend_q[COORD_W-1:0];
         end
         if (load) pend_q <= load_word;
      end
   end

   assign pend_word = pend_q;
endmodule

// File: rtl/curs_plane_ram.sv
module curs_plane_ram #(
   parameter int unsigned SIZE = 32,
   localparam int unsigned IDX_W = $clog2(SIZE)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [SIZE-1:0]  wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [SIZE-1:0]  rdata
);
   logic [SIZE-1:0] rows [SIZE];

   always_ff @(posedge clk) begin
      if (we) rows[widx] <= wdata;
      rdata <= rows[ridx];
   end
endmodule

// File: rtl/curs_window.sv
module curs_window #(
   parameter int unsigned COORD_W = 16,
   parameter int unsigned SIZE    = 32,
   localparam int unsigned IDX_W  = $clog2(SIZE)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pix_valid,
   input  logic signed [COORD_W-1:0] pix_x,
   input  logic signed [COORD_W-1:0] pix_y,
   input  logic signed [COORD_W-1:0] act_x,
   input  logic signed [COORD_W-1:0] act_y,
   output logic [IDX_W-1:0]          row_idx,
   output logic                      s1_valid,
   output logic                      s1_inside,
   output logic [IDX_W-1:0]          s1_col
);
   logic signed [COORD_W:0] dx, dy;
   logic in_x, in_y;

   always_comb begin
      dx = {pix_x[COORD_W-1], pix_x} - {act_x[COORD_W-1], act_x};
      dy = {pix_y[COORD_W-1], pix_y} - {act_y[COORD_W-1], act_y};
      in_x = (dx[COORD_W:IDX_W] == '0);
      in_y = (dy[COORD_W:IDX_W] == '0);
      row_idx = dy[IDX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_inside <= 1'b0;
         s1_col    <= '0;
      end else begin
         s1_valid  <= pix_valid;
         s1_inside <= pix_valid & in_x & in_y;
         s1_col    <= dx[IDX_W-1:0];
      end
   end
endmodule

// File: rtl/curs_bit_sel.sv
module curs_bit_sel #(
   parameter int unsigned SIZE     = 32,
   parameter bit          MSB_LEFT = 1'b1,
   localparam int unsigned IDX_W   = $clog2(SIZE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s1_valid,
   input  logic             s1_inside,
   input  logic [IDX_W-1:0] s1_col,
   input  logic [SIZE-1:0]  mask_row,
   input  logic [SIZE-1:0]  img_row,
   output logic             o_valid,
   output logic             o_hit,
   output logic             o_sel
);
   logic [IDX_W-1:0] bit_pos;
   logic m_bit, i_bit;

   generate
      if (MSB_LEFT) begin : g_msb_left
         assign bit_pos = IDX_W'(SIZE - 1) - s1_col;
      end else begin : g_lsb_left
         assign bit_pos = s1_col;
      end
   endgenerate

   assign m_bit = mask_row[bit_pos];
   assign i_bit = img_row[bit_pos];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_hit   <= 1'b0;
         o_sel   <= 1'b0;
      end else begin
         o_valid <= s1_valid;
         o_hit   <= s1_inside & m_bit;
         o_sel   <= s1_inside & m_bit & i_bit;
      end
   end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
   parameter int unsigned COORD_W  = 16,
   parameter int unsigned SIZE     = 32,
   parameter int unsigned PIX_W    = 24,
   parameter bit          MSB_LEFT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_sel,
   input  logic [$clog2(SIZE)-1:0]  wr_idx,
   input  logic [2*COORD_W-1:0]     wr_data,
   input  logic                     frame_start,
   input  logic                     pix_valid,
   input  logic [COORD_W-1:0]       pix_x,
   input  logic [COORD_W-1:0]       pix_y,
   input  logic [PIX_W-1:0]         pix_in,
   output logic                     out_valid,
   output logic                     out_hit,
   output logic                     out_color_sel,
   output logic [PIX_W-1:0]         out_pix
);
   import curs_pkg::*;

   localparam int unsigned IDX_W  = $clog2(SIZE);
   localparam int unsigned DATA_W = 2 * COORD_W;

   generate
      if ((SIZE & (SIZE - 1)) != 0 || SIZE < 2) begin : g_bad_size
         $error("cursor_overlay: SIZE must be a power of two of at least 2");
      end
      if (SIZE > DATA_W) begin : g_bad_width
         $error("cursor_overlay: a row word must fit in the write data");
      end
      if (COORD_W <= IDX_W) begin : g_bad_coord
         $error("cursor_overlay: COORD_W must exceed log2(SIZE)");
      end
   endgenerate

   wr_tgt_e tgt;
   assign tgt = wr_tgt_e'(wr_sel);

   logic signed [COORD_W-1:0] act_x, act_y;
   logic [DATA_W-1:0]         pend_word;

   curs_pos_reg #(.COORD_W(COORD_W), .HIDE_AT(-int'(SIZE))) u_pos (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_en && tgt == TGT_POS),
      .load_word (wr_data),
      .commit    (frame_start),
      .pend_word (pend_word),
      .act_x     (act_x),
      .act_y     (act_y)
   );

   logic [IDX_W-1:0] row_idx;
   logic             s1_valid, s1_inside;
   logic [IDX_W-1:0] s1_col;

   curs_window #(.COORD_W(COORD_W), .SIZE(SIZE)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_valid (pix_valid),
      .pix_x     (pix_x),
      .pix_y     (pix_y),
      .act_x     (act_x),
      .act_y     (act_y),
      .row_idx   (row_idx),
      .s1_valid  (s1_valid),
      .s1_inside (s1_inside),
      .s1_col    (s1_col)
   );

   logic [SIZE-1:0] plane_row [NUM_PLANES];

   generate
      for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
         localparam wr_tgt_e MY_TGT = (p == PLANE_MASK) ? TGT_MASK : TGT_IMG;
         curs_plane_ram #(.SIZE(SIZE)) u_ram (
            .clk   (clk),
            .we    (wr_en && tgt == MY_TGT),
            .widx  (wr_idx),
            .wdata (wr_data[SIZE-1:0]),
            .ridx  (row_idx),
            .rdata (plane_row[p])
         );
      end
   endgenerate

   curs_bit_sel #(.SIZE(SIZE), .MSB_LEFT(MSB_LEFT)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .s1_valid  (s1_valid),
      .s1_inside (s1_inside),
      .s1_col    (s1_col),
      .mask_row  (plane_row[PLANE_MASK]),
      .img_row   (plane_row[PLANE_IMG]),
      .o_valid   (out_valid),
      .o_hit     (out_hit),
      .o_sel     (out_color_sel)
   );

   logic [PIX_W-1:0] pix_s1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_s1  <= '0;
         out_pix <= '0;
      end else begin
         pix_s1  <= pix_in;
         out_pix <= pix_s1;
      end
   end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
   parameter int unsigned COORD_W = 16,
   parameter int unsigned PIX_W   = 24
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     frame_start,
   input logic                     pix_valid,
   input logic [PIX_W-1:0]         pix_in,
   input logic                     out_valid,
   input logic                     out_hit,
   input logic                     out_color_sel,
   input logic [PIX_W-1:0]         out_pix,
   input logic [COORD_W-1:0]       act_x,
   input logic [COORD_W-1:0]       act_y,
   input logic [2*COORD_W-1:0]     pend_word
);
   p_hit_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> out_valid);

   p_sel_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_color_sel |-> out_hit);

   p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> ##1 out_valid);

   p_idle_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> ##1 !out_valid);

   p_pix_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_pix == $past(pix_in, 2));

   p_pos_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable({act_x, act_y}));

   p_pos_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> {act_x, act_y} == $past(pend_word));
endmodule

bind cursor_overlay cursor_overlay_chk #(.COORD_W(COORD_W), .PIX_W(PIX_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .frame_start   (frame_start),
   .pix_valid     (pix_valid),
   .pix_in        (pix_in),
   .out_valid     (out_valid),
   .out_hit       (out_hit),
   .out_color_sel (out_color_sel),
   .out_pix       (out_pix),
   .act_x         (act_x),
   .act_y         (act_y),
   .pend_word     (pend_word)
);

// File: tb/test_cursor_overlay.sv
`timescale 1ns/1ps
module test_cursor_overlay;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_en = 0;
   logic [1:0]  wr_sel = 0;
   logic [4:0]  wr_idx = 0;
   logic [31:0] wr_data = 0;
   logic        frame_start = 0;
   logic        pix_valid = 0;
   logic [15:0] pix_x = 0, pix_y = 0;
   logic [23:0] pix_in = 0;
   logic        out_valid, out_hit, out_color_sel;
   logic [23:0] out_pix;

   always #2 clk = ~clk;

   cursor_overlay i_cursor_overlay (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
      .wr_data(wr_data), .frame_start(frame_start), .pix_valid(pix_valid),
      .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in), .out_valid(out_valid),
      .out_hit(out_hit), .out_color_sel(out_color_sel), .out_pix(out_pix)
   );

   int n_cmp = 0, n_bad = 0;
   string cur_req = "R1";
   bit done = 0;

   // behavioural reference
   logic [31:0] m_mask [32];
   logic [31:0] m_img  [32];
   logic [31:0] m_pend, m_act;
   logic q1_v, q1_h, q1_s, q2_v, q2_h, q2_s;
   logic [23:0] q1_p, q2_p;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = 32'hFFE0_FFE0;
         m_act  = 32'hFFE0_FFE0;
         {q1_v, q1_h, q1_s, q2_v, q2_h, q2_s} = '0;
         q1_p = '0; q2_p = '0;
      end else begin
         int cx, cy, dx, dy;
         logic h, s;
         cx = int'($signed(m_act[31:16]));
         cy = int'($signed(m_act[15:0]));
         dx = int'($signed(pix_x)) - cx;
         dy = int'($signed(pix_y)) - cy;
         h = 0; s = 0;
         if (pix_valid && dx >= 0 && dx < 32 && dy >= 0 && dy < 32) begin
            h = m_mask[dy][31-dx];
            s = h & m_img[dy][31-dx];
         end
         q2_v = q1_v; q2_h = q1_h; q2_s = q1_s; q2_p = q1_p;
         q1_v = pix_valid; q1_h = h; q1_s = s; q1_p = pix_in;
         if (frame_start) m_act = m_pend;
         if (wr_en) begin
            case (wr_sel)
               2'd0: m_pend = wr_data;
               2'd1: m_mask[wr_idx] = wr_data;
               2'd2: m_img[wr_idx] = wr_data;
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_cmp++;
         if (out_valid !== q2_v || out_hit !== q2_h || out_color_sel !== q2_s ||
             (q2_v && out_pix !== q2_p)) begin
            n_bad++;
            $display("FAIL %s: got v=%0b h=%0b s=%0b p=%h, expected v=%0b h=%0b s=%0b p=%h",
                     cur_req, out_valid, out_hit, out_color_sel, out_pix,
                     q2_v, q2_h, q2_s, q2_p);
         end
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [4:0] idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic frame();
      @(negedge clk);
      frame_start = 1;
      @(negedge clk);
      frame_start = 0;
   endtask

   task automatic sweep(input int x0, input int x1, input int y0, input int y1);
      for (int y = y0; y <= y1; y++)
         for (int x = x0; x <= x1; x++) begin
            @(negedge clk);
            pix_valid = 1; pix_x = 16'(x); pix_y = 16'(y);
            pix_in = 24'($urandom);
         end
      @(negedge clk);
      pix_valid = 0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int r = 0; r < 32; r++) begin m_mask[r] = 0; m_img[r] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1: outputs quiet after reset, cursor hidden
      @(negedge clk);
      n_cmp++;
      if (out_valid !== 0 || out_hit !== 0 || out_color_sel !== 0) begin
         n_bad++;
         $display("FAIL R1: got %0b%0b%0b, expected 000", out_valid, out_hit, out_color_sel);
      end
      // R4: load planes
      cur_req = "R4";
      for (int r = 0; r < 32; r++) begin
         wr(2'd1, 5'(r), (32'hA5C3_3C5A ^ (32'(r) * 32'h0111_0111)) | 32'h8000_0001);
         wr(2'd2, 5'(r), 32'(r) * 32'h1357_9BDF);
      end
      cur_req = "R1";
      sweep(0, 40, 0, 3);
      // R2/R3: pending position not yet active
      cur_req = "R3";
      wr(2'd0, 0, {16'd10, 16'd20});
      sweep(8, 44, 18, 22);
      // R5/R6/R7: active after frame_start
      frame();
      cur_req = "R5";
      sweep(8, 43, 18, 53);
      // R9: negative position clipped
      cur_req = "R9";
      wr(2'd0, 0, {16'hFFFB, 16'hFFF9});
      frame();
      sweep(-2, 30, -1, 26);
      // R10: target 3 touches nothing
      cur_req = "R10";
      wr(2'd3, 5'd7, 32'h0);
      wr(2'd3, 5'd2, 32'hFFFF_FFFF);
      frame();
      sweep(0, 27, 0, 25);
      // R3: write in same cycle as frame_start waits
      cur_req = "R3";
      wr(2'd0, 0, {16'd100, 16'd50});
      @(negedge clk);
      wr_en = 1; wr_sel = 0; wr_data = {16'd3, 16'd4}; frame_start = 1;
      @(negedge clk);
      wr_en = 0; frame_start = 0;
      sweep(0, 36, 2, 6);
      sweep(98, 132, 48, 83);
      frame();
      sweep(0, 36, 2, 37);
      // R4: same-row write while reading returns old data
      cur_req = "R4";
      for (int r = 0; r < 8; r++) begin
         @(negedge clk);
         wr_en = 1; wr_sel = 1; wr_idx = 5'(r); wr_data = ~m_mask[r];
         pix_valid = 1; pix_x = 16'(3 + r); pix_y = 16'(4 + r); pix_in = 24'(r);
      end
      @(negedge clk);
      wr_en = 0; pix_valid = 0;
      sweep(0, 36, 2, 12);
      // R6: single-pixel corner shapes
      cur_req = "R6";
      wr(2'd1, 5'd0, 32'h8000_0000);
      wr(2'd1, 5'd31, 32'h0000_0001);
      wr(2'd2, 5'd0, 32'h8000_0000);
      sweep(2, 36, 3, 5);
      sweep(2, 36, 34, 36);
      // R8: sparse valid, random pixels
      cur_req = "R8";
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         pix_valid = 1'($urandom);
         pix_x = 16'($urandom_range(0, 40));
         pix_y = 16'($urandom_range(0, 40));
         pix_in = 24'($urandom);
      end
      @(negedge clk);
      pix_valid = 0;
      // R1/R2: hide again at -32
      cur_req = "R2";
      wr(2'd0, 0, 32'hFFE0_FFE0);
      frame();
      sweep(0, 33, 0, 33);
      repeat (4) @(negedge clk);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog %s: got hung run, expected completion", cur_req);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule